// File: doc/BRIEF.md
# Accumulator ALU for an 8-bit processor

This block is the arithmetic and logic unit of a small accumulator-style processor. It is purely combinational. It takes two operands, a 4-bit operation code and the four current condition flags: carry, overflow, zero and negative. In the same cycle it returns a result and the four next flags.

Flags that an operation does not define pass through from their inputs unchanged. The surrounding core can therefore write all four flags back to its status register on every operation. The unit also returns the A operand unchanged for the two operations that only set flags (compare and bit test). The core can then write the result back unconditionally as well.

Operand width is a parameter. It may be 8 (the default) or 16. Any other value stops elaboration. The sign bit is the top bit of the width. The bit-test overflow bit is the bit just below it.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add) gives res = (A + B + Cin) modulo 2^W. C is set when the full sum reaches 2^W. V is set when A and B have equal signs and the sign of res differs from them.
- R2: Op code 1 (subtract) gives res = A + ~B + Cin modulo 2^W, where Cin = 1 means no borrow. C is the carry of that sum, so 0 - 1 with Cin = 1 gives all ones with C = 0. V follows the R1 rule applied to A and ~B.
- R3: Op codes 2, 3 and 4 give A AND B, A OR B and A XOR B. C and V keep their input values.
- R4: Op code 5 shifts A left and fills the LSB with 0, with C = old MSB. Op code 6 shifts A right and fills the MSB with 0, with C = old LSB. V keeps its input value.
- R5: Op code 7 rotates A left, with Cin entering the LSB and C = old MSB. Op code 8 rotates A right, with Cin entering the MSB and C = old LSB. V keeps its input value.
- R6: Op code 9 gives A + 1 and op code 10 gives A - 1, both wrapping modulo 2^W. C and V keep their input values.
- R7: Op code 11 (compare) returns A unchanged. C = (A >= B) unsigned, Z = (A == B), N = MSB of (A - B), and V keeps its input value.
- R8: Op code 12 (bit test) returns A unchanged. Z = ((A & B) == 0), N = MSB of A & B, V = bit W-2 of A & B, and C keeps its input value.
- R9: Op codes 13, 14 and 15 return A and all four flags exactly as they came in.
- R10: For op codes 0 to 10, Z = (res == 0) and N = MSB of res, whatever the input Z and N were.
- R11: The outputs follow the inputs within the same cycle, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_a | input | W | Operand A (the accumulator side) |
| i_b | input | W | Operand B |
| i_op | input | 4 | Operation code, 0 to 15 |
| i_cin | input | 1 | Carry flag in |
| i_vin | input | 1 | Overflow flag in |
| i_zin | input | 1 | Zero flag in |
| i_nin | input | 1 | Negative flag in |
| o_res | output | W | Result |
| o_c | output | 1 | Carry flag out |
| o_v | output | 1 | Overflow flag out |
| o_z | output | 1 | Zero flag out |
| o_n | output | 1 | Negative flag out |

## Verification
One operation can drive carry and overflow from the same shared adder at once, and a correct unit must report both together. The vectors provoke this with 0x80 + 0x80, which must give a zero result with C, V and Z all set. They also use 0x80 - 1, which must set V while C stays set. Compare is a second case where two outputs move in the same evaluation: the flags change while the result must still equal A. The vectors judge this with equal, lower and higher operands, checking the result and all four flags together.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_ASL = 4'd5,
    OP_LSR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10,
    OP_CMP = 4'd11,
    OP_BIT = 4'd12
  } alu_op_e;
endpackage

// File: rtl/acc_alu_adder.sv
// Shared adder: add, subtract, compare, increment and decrement all use it.
module acc_alu_adder
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   i_op,
  input  logic [W-1:0] i_a,
  input  logic [W-1:0] i_b,
  input  logic         i_cin,
  output logic [W-1:0] o_sum,
  output logic         o_c,
  output logic         o_v
);
  localparam int MSB = W - 1;

  logic [W-1:0] y;
  logic         c0;
  logic [W:0]   wide;

  always_comb begin
    case (alu_op_e'(i_op))
      OP_SUB:  begin y = ~i_b;        c0 = i_cin; end
      OP_CMP:  begin y = ~i_b;        c0 = 1'b1;  end
      OP_INC:  begin y = '0;          c0 = 1'b1;  end
      OP_DEC:  begin y = '1;          c0 = 1'b0;  end
      default: begin y = i_b;         c0 = i_cin; end
    endcase
    wide = {1'b0, i_a} + {1'b0, y} + {{W{1'b0}}, c0};
  end

  assign o_sum = wide[W-1:0];
  assign o_c   = wide[W];
  assign o_v   = (i_a[MSB] == y[MSB]) && (wide[MSB] != i_a[MSB]);
endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise unit: the AND output also feeds the bit-test flags.
module acc_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] i_a,
  input  logic [W-1:0] i_b,
  output logic [W-1:0] o_and,
  output logic [W-1:0] o_or,
  output logic [W-1:0] o_xor
);
  assign o_and = i_a & i_b;
  assign o_or  = i_a | i_b;
  assign o_xor = i_a ^ i_b;
endmodule

// File: rtl/acc_alu_shift.sv
// One-place shifter: logical shifts fill with zero, rotates pass through carry.
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   i_op,
  input  logic [W-1:0] i_a,
  input  logic         i_cin,
  output logic [W-1:0] o_res,
  output logic         o_c
);
  always_comb begin
    case (alu_op_e'(i_op))
      OP_ASL:  {o_c, o_res} = {i_a, 1'b0};
      OP_LSR:  {o_res, o_c} = {1'b0, i_a};
      OP_ROL:  {o_c, o_res} = {i_a, i_cin};
      OP_ROR:  {o_res, o_c} = {i_cin, i_a};
      default: {o_c, o_res} = {i_cin, i_a};
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] i_a,
  input  logic [W-1:0] i_b,
  input  logic [3:0]   i_op,
  input  logic         i_cin,
  input  logic         i_vin,
  input  logic         i_zin,
  input  logic         i_nin,
  output logic [W-1:0] o_res,
  output logic         o_c,
  output logic         o_v,
  output logic         o_z,
  output logic         o_n
);
  localparam int MSB  = W - 1;
  localparam int VBIT = W - 2;

  if (W != 8 && W != 16) begin : g_bad_width
    $error("acc_alu: W must be 8 or 16");
  end

  logic [W-1:0] add_sum, and_r, or_r, xor_r, sh_res;
  logic         add_c, add_v, sh_c;

  acc_alu_adder #(.W(W)) u_adder (
    .i_op(i_op), .i_a(i_a), .i_b(i_b), .i_cin(i_cin),
    .o_sum(add_sum), .o_c(add_c), .o_v(add_v)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .i_a(i_a), .i_b(i_b), .o_and(and_r), .o_or(or_r), .o_xor(xor_r)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .i_op(i_op), .i_a(i_a), .i_cin(i_cin), .o_res(sh_res), .o_c(sh_c)
  );

  logic [W-1:0] res;
  logic         c, v, z, n, upd_zn;

  always_comb begin
    res    = i_a;
    c      = i_cin;
    v      = i_vin;
    z      = i_zin;
    n      = i_nin;
    upd_zn = 1'b0;
    case (alu_op_e'(i_op))
      OP_ADD, OP_SUB: begin
        res = add_sum; c = add_c; v = add_v; upd_zn = 1'b1;
      end
      OP_AND: begin res = and_r; upd_zn = 1'b1; end
      OP_OR:  begin res = or_r;  upd_zn = 1'b1; end
      OP_XOR: begin res = xor_r; upd_zn = 1'b1; end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res = sh_res; c = sh_c; upd_zn = 1'b1;
      end
      OP_INC, OP_DEC: begin res = add_sum; upd_zn = 1'b1; end
      OP_CMP: begin
        c = add_c; z = (add_sum == '0); n = add_sum[MSB];
      end
      OP_BIT: begin
        z = (and_r == '0); n = and_r[MSB]; v = and_r[VBIT];
      end
      default: ;
    endcase
    if (upd_zn) begin
      z = (res == '0);
      n = res[MSB];
    end
  end

  assign o_res = res;
  assign o_c   = c;
  assign o_v   = v;
  assign o_z   = z;
  assign o_n   = n;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] i_a,
  input logic [W-1:0] i_b,
  input logic [3:0]   i_op,
  input logic         i_cin,
  input logic         i_vin,
  input logic         i_zin,
  input logic         i_nin,
  input logic [W-1:0] o_res,
  input logic         o_c,
  input logic         o_v,
  input logic         o_z,
  input logic         o_n
);
  always_comb begin
    if (i_op == 4'd0) begin
      // R1
      add_sum_chk: assert ({o_c, o_res} == ({1'b0, i_a} + {1'b0, i_b} + {{W{1'b0}}, i_cin}));
    end
    if (i_op == 4'd1) begin
      // R2
      sub_borrow_chk: assert ({o_c, o_res} == ({1'b0, i_a} + {1'b0, ~i_b} + {{W{1'b0}}, i_cin}));
    end
    if (i_op == 4'd5) begin
      // R4
      asl_fill_chk: assert (o_res[0] == 1'b0 && o_c == i_a[W-1] && o_v == i_vin);
    end
    if (i_op == 4'd11) begin
      // R7
      cmp_keep_chk: assert (o_res == i_a && o_c == (i_a >= i_b) && o_v == i_vin);
    end
    if (i_op == 4'd12) begin
      // R8
      bit_vflag_chk: assert (o_res == i_a && o_c == i_cin && o_v == (i_a[W-2] & i_b[W-2]));
    end
    if (i_op >= 4'd13) begin
      // R9
      pass_through_chk: assert (o_res == i_a && o_c == i_cin && o_v == i_vin
                                && o_z == i_zin && o_n == i_nin);
    end
    if (i_op <= 4'd10) begin
      // R10
      zero_neg_chk: assert (o_z == (o_res == '0) && o_n == o_res[W-1]);
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .i_a(i_a), .i_b(i_b), .i_op(i_op), .i_cin(i_cin), .i_vin(i_vin),
  .i_zin(i_zin), .i_nin(i_nin), .o_res(o_res), .o_c(o_c), .o_v(o_v),
  .o_z(o_z), .o_n(o_n)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a, b, res;
  logic [3:0] op;
  logic cin, vin, zin, nin, c, v, z, n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  acc_alu #(.W(8)) i_acc_alu (
    .i_a(a), .i_b(b), .i_op(op), .i_cin(cin), .i_vin(vin), .i_zin(zin),
    .i_nin(nin), .o_res(res), .o_c(c), .o_v(v), .o_z(z), .o_n(n)
  );

  // {req, op, a, b, flags in (c v z n), expected res, expected flags (c v z n)}
  localparam int NV = 34;
  localparam logic [39:0] VEC [NV] = '{
    40'h1_0_01_0A_0_0B_0,  // R1 plain add
    40'h1_0_50_50_0_A0_5,  // R1 signed overflow
    40'h1_0_80_80_0_00_E,  // R1 carry and overflow together
    40'h1_0_FF_00_8_00_A,  // R1 carry-in wraps
    40'h2_1_00_01_8_FF_1,  // R2 0-1 clears carry
    40'h2_1_FF_01_8_FE_9,  // R2 255-1 keeps carry
    40'h2_1_80_01_8_7F_C,  // R2 signed overflow
    40'h2_1_05_03_0_01_8,  // R2 with borrow
    40'h3_2_21_01_C_01_C,  // R3 AND, C V pass
    40'h3_3_F0_0F_0_FF_1,  // R3 OR
    40'h3_4_AA_AA_8_00_A,  // R3 XOR to zero
    40'h4_5_FF_00_4_FE_D,  // R4 ASL carry out
    40'h4_5_40_00_8_80_1,  // R4 ASL zero fill
    40'h4_6_01_00_4_00_E,  // R4 LSR carry out
    40'h4_6_FE_00_8_7F_0,  // R4 LSR zero fill
    40'h5_7_FF_00_0_FE_9,  // R5 ROL
    40'h5_7_01_00_8_03_0,  // R5 ROL carry in
    40'h5_8_FF_00_8_FF_9,  // R5 ROR
    40'h5_8_01_00_0_00_A,  // R5 ROR to zero
    40'h5_8_00_00_8_80_1,  // R5 ROR carry into MSB
    40'h6_9_FF_00_4_00_6,  // R6 INC wraps
    40'h6_9_7F_00_8_80_9,  // R6 INC to negative
    40'h6_A_00_00_C_FF_D,  // R6 DEC wraps
    40'h6_A_01_00_0_00_2,  // R6 DEC to zero
    40'h7_B_40_40_4_40_E,  // R7 equal
    40'h7_B_10_20_8_10_1,  // R7 lower
    40'h7_B_20_10_0_20_8,  // R7 higher
    40'h8_C_C0_FF_8_C0_D,  // R8 N and V from AND
    40'h8_C_0F_F0_4_0F_2,  // R8 zero AND
    40'h8_C_40_40_0_40_4,  // R8 V alone
    40'h9_D_5A_00_A_5A_A,  // R9 code 13
    40'h9_E_33_44_F_33_F,  // R9 code 14
    40'h9_F_00_00_5_00_5,  // R9 code 15, Z kept clear on zero result
    40'h1_0_7F_01_0_80_5   // R1 R10 Z and N from result
  };

  task automatic drive(input logic [3:0] o, input logic [7:0] xa, input logic [7:0] xb,
                       input logic [3:0] fl);
    @(negedge clk);
    op = o; a = xa; b = xb;
    {cin, vin, zin, nin} = fl;
    #2;
  endtask

  task automatic check(input string tag, input logic [7:0] er, input logic [3:0] ef);
    checks++;
    if (res !== er || {c, v, z, n} !== ef) begin
      errors++;
      $display("FAIL %s: res=%h cvzn=%b expected res=%h cvzn=%b", tag, res, {c, v, z, n}, er, ef);
    end
  endtask

  initial begin
    op = 4'd0; a = '0; b = '0; {cin, vin, zin, nin} = 4'b0000;
    #3;
    // idle state: all-zero inputs add to zero with Z set (R10)
    check("R10 idle", 8'h00, 4'b0010);

    for (int k = 0; k < NV; k++) begin
      logic [39:0] e;
      string tag;
      e = VEC[k];
      drive(e[35:32], e[31:24], e[23:16], e[15:12]);
      tag = $sformatf("R%0d vec %0d", e[39:36], k);
      check(tag, e[11:4], e[3:0]);
    end

    // R11: output follows inputs with no clock edge in between
    @(negedge clk);
    op = 4'd5; a = 8'h81; {cin, vin, zin, nin} = 4'b0000;
    #1 check("R11 asl", 8'h02, 4'b1000);
    op = 4'd8; cin = 1'b1;
    #1 check("R11 ror", 8'hC0, 4'b1001);

    // R10: stale input Z and N overridden by the result
    drive(4'd2, 8'h0F, 8'hF0, 4'b0001);
    check("R10 and", 8'h00, 4'b0010);

    // R7: compare of zero against max leaves A, clears carry
    drive(4'd11, 8'h00, 8'hFF, 4'b1000);
    check("R7 zero vs max", 8'h00, 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule